// File: doc/BRIEF.md
# Matrix Scroll Offset Engine

This block produces the row and column offsets that a dot-matrix scanner adds to its frame-buffer addresses, so that the shown picture slides by one dot per step. A run is started with a strobe. After the strobe it advances the offset on one axis once per step period. The period is a multiple of a millisecond tick. The run stops after a programmed number of steps and holds the reached position. At that point it raises a sticky end-of-scroll flag, which feeds an interrupt output together with flags from neighbouring blocks.

The engine serves two matrix geometries: a full one of 7 rows by 17 columns and a compact one of 5 rows by 15 columns. It also has a page-alternation mode. In that mode the moving axis spans two page widths and the page select toggles while the picture travels across the second page. Mirroring bits reflect the offsets so that a mirrored display still scrolls coherently. The scanner, pixel fetch and register access live elsewhere.

Top module: `scroll_offset_engine`

## Requirements
- R1: While reset is asserted and directly after it, both offsets are 0, `scroll_flag` and `irq` are 0, and `page_sel` equals `page_base`.
- R2: While running, the moving offset advances exactly once every MS_PER_UNIT × (`step_speed` + 1) pulses of `ms_tick`, and never earlier.
- R3: `dir_sel` selects the axis and the sense of motion: 00 moves columns upward by one (right), 01 moves columns downward by one (left), 10 moves rows upward by one (up), 11 moves rows downward by one (down). The other axis offset stays 0.
- R4: The moving position wraps modulo the page dimension on that axis. With `page_alt` = 1 it wraps modulo twice that dimension.
- R5: The number of steps in a run is `step_count`. A value of 0 means one page dimension of the moving axis, and values above twice that dimension saturate at twice the dimension. Dimensions are 17 columns and 7 rows when `compact_mode` = 0, and 15 columns and 5 rows when `compact_mode` = 1.
- R6: A pulse on `scroll_go` while enabled and not running starts a run from offset 0. After the final step the position is held and further ticks have no effect. A `scroll_go` pulse during a run is ignored.
- R7: `scroll_flag` is set by the final step of a run and stays set until a `flag_clr` pulse. A clear in the same cycle as a final step leaves the flag set.
- R8: `irq` is high whenever `scroll_flag` or any bit of `ext_flags` is high.
- R9: With `page_alt` = 1, `page_sel` is `page_base` inverted while the moving position is at or beyond one page dimension. Otherwise `page_sel` equals `page_base`.
- R10: With `flip_h` (columns) or `flip_v` (rows) set, the reported offset on that axis is (modulus − position) modulo the modulus.
- R11: With `scroll_en` low, both offsets are 0 one clock later, and `scroll_go` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| scroll_en | input | 1 | Scroll enable; low returns offsets to 0 |
| scroll_go | input | 1 | Start strobe |
| dir_sel | input | 2 | Direction: 00 right, 01 left, 10 up, 11 down |
| step_speed | input | SPEED_W | Step period code |
| step_count | input | COUNT_W | Steps per run, 0 = one page |
| page_alt | input | 1 | 1 = alternate current and other page |
| compact_mode | input | 1 | 0 = 7×17 matrix, 1 = 5×15 matrix |
| page_base | input | 1 | Currently selected page |
| flip_h | input | 1 | Mirror column offset |
| flip_v | input | 1 | Mirror row offset |
| flag_clr | input | 1 | Clear strobe for the end-of-scroll flag |
| ext_flags | input | EXT_FLAGS | Sticky flags of neighbouring blocks |
| row_ofs | output | ROW_W | Row offset |
| col_ofs | output | COL_W | Column offset |
| page_sel | output | 1 | Page the scanner should read |
| scroll_flag | output | 1 | Sticky end-of-scroll flag |
| irq | output | 1 | Combined interrupt |

## Verification
The main function is swept over both geometries, all four directions, both page modes and ten step counts per case: zero, one, two, one either side of one page and of two pages, and the largest code. These runs separate wrap at one page from wrap at two pages, reveal an off-by-one in saturation, and show a wrong sense of motion for each direction. Mirroring and page base alternate across the sweep, so reflection and page toggling are seen in both halves of the range. Dedicated runs with long step periods check that no step comes one tick early. Other runs cover a start strobe during a run, a start while disabled, a clear that collides with the final step, and a disable in the middle of a run.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } scroll_state_e;
endpackage

// File: rtl/scroll_timer.sv
// Divides the millisecond tick into step periods of MS_PER_UNIT*(speed+1).
module scroll_timer #(
  parameter int MS_PER_UNIT = 50,
  parameter int SPEED_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               running,
  input  logic               ms_tick,
  input  logic [SPEED_W-1:0] speed,
  output logic               step_due
);
  localparam int PER_W = $clog2(MS_PER_UNIT * (1 << SPEED_W) + 1);

  logic [SPEED_W-1:0] speed_q, speed_d;
  logic [PER_W-1:0]   cnt_q, cnt_d;
  logic [PER_W-1:0]   last_cnt;

  always_comb begin
    last_cnt = PER_W'(MS_PER_UNIT * (int'(speed_q) + 1) - 1);
    step_due = running && ms_tick && (cnt_q == last_cnt);
    speed_d  = start ? speed : speed_q;
    if (start || !running) begin
      cnt_d = '0;
    end else if (ms_tick) begin
      cnt_d = step_due ? '0 : cnt_q + PER_W'(1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speed_q <= '0;
      cnt_q   <= '0;
    end else begin
      speed_q <= speed_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/scroll_axis.sv
// One axis position counter with modular wrap and optional reflection.
module scroll_axis #(
  parameter int W         = 6,
  parameter bit MIRROR_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic         dec,
  input  logic [W-1:0] modulus,
  input  logic [W-1:0] dim,
  input  logic         mirror,
  output logic [W-1:0] ofs,
  output logic         upper
);
  logic [W-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (clr) begin
      pos_d = '0;
    end else if (step) begin
      if (dec) begin
        pos_d = (pos_q == '0) ? modulus - W'(1) : pos_q - W'(1);
      end else begin
        pos_d = (pos_q == modulus - W'(1)) ? '0 : pos_q + W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else begin
      pos_q <= pos_d;
    end
  end

  assign upper = (pos_q >= dim);

  generate
    if (MIRROR_EN) begin : g_mirror
      assign ofs = (mirror && pos_q != '0) ? modulus - pos_q : pos_q;
    end else begin : g_plain
      logic unused_mirror;
      assign unused_mirror = mirror;
      assign ofs = pos_q;
    end
  endgenerate
endmodule

// File: rtl/scroll_ctrl.sv
// Run sequencing: start, step counting, hold and sticky end flag.
module scroll_ctrl
  import scroll_pkg::*;
#(
  parameter int FULL_ROWS  = 7,
  parameter int FULL_COLS  = 17,
  parameter int SMALL_ROWS = 5,
  parameter int SMALL_COLS = 15,
  parameter int COUNT_W    = 6,
  parameter int COL_W      = 6,
  parameter int ROW_W      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               go,
  input  logic [1:0]         dir,
  input  logic [COUNT_W-1:0] count,
  input  logic               alt,
  input  logic               compact,
  input  logic               step_due,
  input  logic               flag_clr,
  output logic               start,
  output logic               running,
  output logic               holding,
  output logic               final_step,
  output logic               move_col,
  output logic               move_row,
  output logic               move_dec,
  output logic               horiz,
  output logic               alt_q,
  output logic [COL_W-1:0]   col_mod,
  output logic [ROW_W-1:0]   row_mod,
  output logic [COL_W-1:0]   col_dim,
  output logic [ROW_W-1:0]   row_dim,
  output logic               flag
);
  scroll_state_e      state_q, state_d;
  logic [1:0]         dir_q, dir_d;
  logic               alt_d;
  logic               compact_q, compact_d;
  logic [COUNT_W-1:0] target_q, target_d;
  logic [COUNT_W-1:0] steps_q, steps_d;
  logic               flag_q, flag_d;
  logic [COUNT_W-1:0] live_dim, live_lim, live_target;
  logic               advance;

  always_comb begin
    if (dir[1]) begin
      live_dim = compact ? COUNT_W'(SMALL_ROWS) : COUNT_W'(FULL_ROWS);
    end else begin
      live_dim = compact ? COUNT_W'(SMALL_COLS) : COUNT_W'(FULL_COLS);
    end
    live_lim = live_dim << 1;
    if (count == '0) begin
      live_target = live_dim;
    end else if (count > live_lim) begin
      live_target = live_lim;
    end else begin
      live_target = count;
    end
  end

  assign start      = en && go && (state_q != ST_RUN);
  assign running    = en && (state_q == ST_RUN);
  assign holding    = (state_q == ST_HOLD);
  assign advance    = running && step_due;
  assign final_step = advance && (steps_q + COUNT_W'(1) == target_q);

  always_comb begin
    state_d   = state_q;
    dir_d     = dir_q;
    alt_d     = alt_q;
    compact_d = compact_q;
    target_d  = target_q;
    steps_d   = steps_q;
    if (!en) begin
      state_d = ST_IDLE;
      steps_d = '0;
    end else if (start) begin
      state_d   = ST_RUN;
      dir_d     = dir;
      alt_d     = alt;
      compact_d = compact;
      target_d  = live_target;
      steps_d   = '0;
    end else if (final_step) begin
      state_d = ST_HOLD;
      steps_d = steps_q + COUNT_W'(1);
    end else if (advance) begin
      steps_d = steps_q + COUNT_W'(1);
    end
    if (final_step) begin
      flag_d = 1'b1;
    end else if (flag_clr) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      dir_q     <= 2'b00;
      alt_q     <= 1'b0;
      compact_q <= 1'b0;
      target_q  <= '0;
      steps_q   <= '0;
      flag_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      dir_q     <= dir_d;
      alt_q     <= alt_d;
      compact_q <= compact_d;
      target_q  <= target_d;
      steps_q   <= steps_d;
      flag_q    <= flag_d;
    end
  end

  assign horiz    = !dir_q[1];
  assign move_col = advance && horiz;
  assign move_row = advance && !horiz;
  assign move_dec = dir_q[0];
  assign col_dim  = compact_q ? COL_W'(SMALL_COLS) : COL_W'(FULL_COLS);
  assign row_dim  = compact_q ? ROW_W'(SMALL_ROWS) : ROW_W'(FULL_ROWS);
  assign col_mod  = alt_q ? (col_dim << 1) : col_dim;
  assign row_mod  = alt_q ? (row_dim << 1) : row_dim;
  assign flag     = flag_q;
endmodule

// File: rtl/scroll_offset_engine.sv
module scroll_offset_engine #(
  parameter int FULL_ROWS   = 7,
  parameter int FULL_COLS   = 17,
  parameter int SMALL_ROWS  = 5,
  parameter int SMALL_COLS  = 15,
  parameter int MS_PER_UNIT = 50,
  parameter int SPEED_W     = 4,
  parameter int COUNT_W     = 6,
  parameter int EXT_FLAGS   = 2,
  localparam int COL_W      = $clog2(2 * FULL_COLS),
  localparam int ROW_W      = $clog2(2 * FULL_ROWS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ms_tick,
  input  logic                 scroll_en,
  input  logic                 scroll_go,
  input  logic [1:0]           dir_sel,
  input  logic [SPEED_W-1:0]   step_speed,
  input  logic [COUNT_W-1:0]   step_count,
  input  logic                 page_alt,
  input  logic                 compact_mode,
  input  logic                 page_base,
  input  logic                 flip_h,
  input  logic                 flip_v,
  input  logic                 flag_clr,
  input  logic [EXT_FLAGS-1:0] ext_flags,
  output logic [ROW_W-1:0]     row_ofs,
  output logic [COL_W-1:0]     col_ofs,
  output logic                 page_sel,
  output logic                 scroll_flag,
  output logic                 irq
);
  logic             start, running, holding, final_step;
  logic             move_col, move_row, move_dec, horiz, alt_q;
  logic             step_due, axis_clr, col_upper, row_upper, flag;
  logic [COL_W-1:0] col_mod, col_dim;
  logic [ROW_W-1:0] row_mod, row_dim;

  scroll_ctrl #(
    .FULL_ROWS(FULL_ROWS), .FULL_COLS(FULL_COLS),
    .SMALL_ROWS(SMALL_ROWS), .SMALL_COLS(SMALL_COLS),
    .COUNT_W(COUNT_W), .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(scroll_en), .go(scroll_go),
    .dir(dir_sel), .count(step_count), .alt(page_alt), .compact(compact_mode),
    .step_due(step_due), .flag_clr(flag_clr),
    .start(start), .running(running), .holding(holding), .final_step(final_step),
    .move_col(move_col), .move_row(move_row), .move_dec(move_dec),
    .horiz(horiz), .alt_q(alt_q),
    .col_mod(col_mod), .row_mod(row_mod), .col_dim(col_dim), .row_dim(row_dim),
    .flag(flag)
  );

  scroll_timer #(.MS_PER_UNIT(MS_PER_UNIT), .SPEED_W(SPEED_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .running(running),
    .ms_tick(ms_tick), .speed(step_speed), .step_due(step_due)
  );

  assign axis_clr = start || !scroll_en;

  scroll_axis #(.W(COL_W), .MIRROR_EN(1'b1)) u_col (
    .clk(clk), .rst_n(rst_n), .clr(axis_clr), .step(move_col), .dec(move_dec),
    .modulus(col_mod), .dim(col_dim), .mirror(flip_h),
    .ofs(col_ofs), .upper(col_upper)
  );

  scroll_axis #(.W(ROW_W), .MIRROR_EN(1'b1)) u_row (
    .clk(clk), .rst_n(rst_n), .clr(axis_clr), .step(move_row), .dec(move_dec),
    .modulus(row_mod), .dim(row_dim), .mirror(flip_v),
    .ofs(row_ofs), .upper(row_upper)
  );

  assign page_sel    = page_base ^ (alt_q && (horiz ? col_upper : row_upper));
  assign scroll_flag = flag;
  assign irq         = flag || (|ext_flags);
endmodule

// File: rtl/scroll_offset_checker.sv
module scroll_offset_checker #(
  parameter int FULL_ROWS = 7,
  parameter int FULL_COLS = 17,
  parameter int COL_W     = 6,
  parameter int ROW_W     = 4,
  parameter int EXT_FLAGS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 scroll_en,
  input logic                 scroll_go,
  input logic                 flag_clr,
  input logic                 flip_h,
  input logic                 flip_v,
  input logic [EXT_FLAGS-1:0] ext_flags,
  input logic [ROW_W-1:0]     row_ofs,
  input logic [COL_W-1:0]     col_ofs,
  input logic                 scroll_flag,
  input logic                 irq,
  input logic                 final_step,
  input logic                 holding
);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scroll_flag && !flag_clr) |=> scroll_flag);

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    final_step |=> scroll_flag);

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !final_step) |=> !scroll_flag);

  assert_disable_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !scroll_en |=> (row_ofs == '0 && col_ofs == '0));

  assert_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(col_ofs) < 2 * FULL_COLS) && (int'(row_ofs) < 2 * FULL_ROWS));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && scroll_en && !scroll_go) ##1 ($stable(flip_h) && $stable(flip_v))
      |-> ($stable(col_ofs) && $stable(row_ofs)));

  assert_irq_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|ext_flags) |-> irq);

  assert_single_axis_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (row_ofs != '0) |-> (col_ofs == '0));
endmodule

bind scroll_offset_engine scroll_offset_checker #(
  .FULL_ROWS(FULL_ROWS), .FULL_COLS(FULL_COLS),
  .COL_W(COL_W), .ROW_W(ROW_W), .EXT_FLAGS(EXT_FLAGS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .scroll_en(scroll_en), .scroll_go(scroll_go),
  .flag_clr(flag_clr), .flip_h(flip_h), .flip_v(flip_v), .ext_flags(ext_flags),
  .row_ofs(row_ofs), .col_ofs(col_ofs), .scroll_flag(scroll_flag), .irq(irq),
  .final_step(final_step), .holding(holding)
);

// File: tb/scroll_offset_engine_tb_top.sv
`timescale 1ns/1ps
module scroll_offset_engine_tb_top;
  localparam int MSU = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0, scroll_en = 1'b0, scroll_go = 1'b0;
  logic [1:0] dir_sel = 2'b00;
  logic [3:0] step_speed = 4'd0;
  logic [5:0] step_count = 6'd0;
  logic       page_alt = 1'b0, compact_mode = 1'b0, page_base = 1'b0;
  logic       flip_h = 1'b0, flip_v = 1'b0, flag_clr = 1'b0;
  logic [1:0] ext_flags = 2'b00;
  logic [3:0] row_ofs;
  logic [5:0] col_ofs;
  logic       page_sel, scroll_flag, irq;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  scroll_offset_engine #(.MS_PER_UNIT(MSU)) dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .scroll_en(scroll_en),
    .scroll_go(scroll_go), .dir_sel(dir_sel), .step_speed(step_speed),
    .step_count(step_count), .page_alt(page_alt), .compact_mode(compact_mode),
    .page_base(page_base), .flip_h(flip_h), .flip_v(flip_v), .flag_clr(flag_clr),
    .ext_flags(ext_flags), .row_ofs(row_ofs), .col_ofs(col_ofs),
    .page_sel(page_sel), .scroll_flag(scroll_flag), .irq(irq)
  );

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic tick();
    @(posedge clk); #1 ms_tick = 1'b1;
    @(posedge clk); #1 ms_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic go();
    @(posedge clk); #1 scroll_go = 1'b1;
    @(posedge clk); #1 scroll_go = 1'b0;
  endtask

  task automatic clear_flag();
    @(posedge clk); #1 flag_clr = 1'b1;
    @(posedge clk); #1 flag_clr = 1'b0;
  endtask

  task automatic disable_cycle();
    @(posedge clk); #1 scroll_en = 1'b0;
    @(posedge clk); #1;
  endtask

  function automatic int pick_count(input int idx, input int dim);
    case (idx)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return dim - 1;
      4: return dim;
      5: return dim + 1;
      6: return 2 * dim - 1;
      7: return 2 * dim;
      8: return 2 * dim + 1;
      default: return 63;
    endcase
  endfunction

  // expected offsets/page after k steps
  task automatic check_state(input int k, input int dir, input int dim, input int alt,
                             input int mir, input int base, input string req);
    int modv, pos, ofs, pg;
    modv = alt ? 2 * dim : dim;
    pos  = (dir % 2 == 1) ? (modv - (k % modv)) % modv : k % modv;
    ofs  = mir ? (modv - pos) % modv : pos;
    pg   = base ^ ((alt != 0 && pos >= dim) ? 1 : 0);
    if (dir < 2) begin
      chk(int'(col_ofs), ofs, req);
      chk(int'(row_ofs), 0, "R3 idle axis");
    end else begin
      chk(int'(row_ofs), ofs, req);
      chk(int'(col_ofs), 0, "R3 idle axis");
    end
    chk(int'(page_sel), pg, "R9 page select");
  endtask

  initial begin
    int dim, tgt, c, mir, base;
    #9;
    // R1: reset state
    chk(int'(row_ofs), 0, "R1 row");
    chk(int'(col_ofs), 0, "R1 col");
    chk(int'(scroll_flag), 0, "R1 flag");
    chk(int'(irq), 0, "R1 irq");
    chk(int'(page_sel), 0, "R1 page");
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk(int'(col_ofs), 0, "R1 after release");

    // Sweep: geometry x direction x page mode x step count
    for (int cm = 0; cm < 2; cm++)
      for (int d = 0; d < 4; d++)
        for (int a = 0; a < 2; a++)
          for (int ci = 0; ci < 10; ci++) begin
            disable_cycle();
            chk(int'(col_ofs) + int'(row_ofs), 0, "R11 offsets zero");
            dim  = (d >= 2) ? (cm ? 5 : 7) : (cm ? 15 : 17);
            c    = pick_count(ci, dim);
            tgt  = (c == 0) ? dim : ((c > 2 * dim) ? 2 * dim : c);
            mir  = ci % 2;
            base = (ci % 3 == 0) ? 1 : 0;
            compact_mode = cm[0]; dir_sel = d[1:0]; page_alt = a[0];
            step_count = c[5:0]; step_speed = 4'd0;
            flip_h = mir[0]; flip_v = mir[0]; page_base = base[0];
            scroll_en = 1'b1;
            go();
            check_state(0, d, dim, a, mir, base, "R6 start at origin");
            for (int k = 1; k <= tgt; k++) begin
              tick();
              check_state(k - 1, d, dim, a, mir, base, "R2 no early step");
              tick();
              check_state(k, d, dim, a, mir, base, "R3 R4 R10 step position");
              chk(int'(scroll_flag), (k == tgt) ? 1 : 0, "R5 R7 flag at final step");
            end
            ticks(4 * MSU);
            check_state(tgt, d, dim, a, mir, base, "R6 hold");
            chk(int'(irq), 1, "R8 irq from flag");
            clear_flag();
            chk(int'(scroll_flag), 0, "R7 clear");
            chk(int'(irq), 0, "R8 irq low");
          end

    // R2: longer periods
    disable_cycle();
    compact_mode = 1'b0; dir_sel = 2'b00; page_alt = 1'b0; step_count = 6'd3;
    flip_h = 1'b0; flip_v = 1'b0; page_base = 1'b0; step_speed = 4'd3;
    scroll_en = 1'b1;
    go();
    ticks(4 * MSU - 1);
    chk(int'(col_ofs), 0, "R2 speed 3 before period");
    tick();
    chk(int'(col_ofs), 1, "R2 speed 3 one period");
    ticks(4 * MSU - 1);
    chk(int'(col_ofs), 1, "R2 speed 3 second period early");
    tick();
    chk(int'(col_ofs), 2, "R2 speed 3 second period");
    disable_cycle();
    step_speed = 4'd15; scroll_en = 1'b1;
    go();
    ticks(16 * MSU - 1);
    chk(int'(col_ofs), 0, "R2 speed 15 before period");
    tick();
    chk(int'(col_ofs), 1, "R2 speed 15 one period");

    // R11: disable mid-run clears next clock; go ignored while disabled
    @(posedge clk); #1 scroll_en = 1'b0;
    @(posedge clk); #1;
    chk(int'(col_ofs), 0, "R11 disable mid run");
    go();
    ticks(4 * MSU);
    chk(int'(col_ofs), 0, "R11 go ignored while disabled");
    chk(int'(scroll_flag), 0, "R11 no flag while disabled");

    // R6: go during run ignored
    step_speed = 4'd0; step_count = 6'd5; dir_sel = 2'b10; scroll_en = 1'b1;
    go();
    ticks(2 * MSU);
    go();
    chk(int'(row_ofs), 2, "R6 go during run keeps position");
    ticks(3 * MSU);
    chk(int'(row_ofs), 5, "R6 run completes");
    chk(int'(scroll_flag), 1, "R6 flag after ignored go");
    ticks(2 * MSU);
    chk(int'(row_ofs), 5, "R6 held after ignored go");

    // R7: clear colliding with final step leaves flag set
    step_count = 6'd1; dir_sel = 2'b00;
    go();
    chk(int'(scroll_flag), 1, "R7 sticky across restart");
    tick();
    @(posedge clk); #1 ms_tick = 1'b1; flag_clr = 1'b1;
    @(posedge clk); #1 ms_tick = 1'b0; flag_clr = 1'b0;
    chk(int'(col_ofs), 1, "R7 final step taken");
    chk(int'(scroll_flag), 1, "R7 set wins over clear");
    clear_flag();
    chk(int'(scroll_flag), 0, "R7 clear afterwards");

    // R8: external flags
    ext_flags = 2'b10; #1;
    chk(int'(irq), 1, "R8 external flag");
    ext_flags = 2'b00; #1;
    chk(int'(irq), 0, "R8 all clear");

    finish_run();
  end
endmodule